// File: doc/BRIEF.md
# Video Front-End Control Register Target (write-only two-wire bus)

This block is a two-wire bus target that only takes writes. It settles the bus clock and data lines into a faster system clock, finds start and stop conditions and rising clock edges, and collects bytes MSB first. It acknowledges each accepted byte by pulling the data line low for the ninth clock. A transfer is: start, the write address byte 0x40, one register index, then any number of data bytes. Each data byte goes to the current index, and the index then steps up by one until a stop condition.

The fifteen stored bytes drive the control fields of a three-channel video front end: overall and per-channel gain, overlay gain, an output-range mode, per-channel black level, common and per-channel trim values, a blanking level and mode, several single-bit mode flags, a detector threshold code and a three-bit auxiliary pin selector. The block also produces derived fields. These are the effective black level of each channel, which follows the green register whenever common mode is chosen or forced by the pin selector, and the function codes of two auxiliary outputs.

Top module: `vfe_ctrl_i2c_target`

## Requirements
- R1: After synchronous reset every register reads 0 except the range mode (index 0x04 bits 5:4), which reads 2. The pull-low output is 0.
- R2: The address byte 0x40 (7-bit address 0x20, write) is acknowledged: sda_pull_o is 1 while SCL is high in the ninth clock of that byte.
- R3: Any other address byte, including 0x41 (read), is not acknowledged. Every later byte up to the next start is neither acknowledged nor written.
- R4: The byte after the address is the index. Each data byte, received MSB first, is written to the current index, and the index then increments by one.
- R5: Data bytes for an index above 0x0E are acknowledged and discarded. The index stops at 0xFF and never wraps to 0x00.
- R6: A repeated start inside a transfer restarts address decoding. The byte after the address is then taken as a new index.
- R7: A stop condition returns the target to idle and does not commit a partially received byte. Bytes clocked after a stop without a new start are ignored and not acknowledged.
- R8: The field map is as follows. 0x00 is the overall gain. 0x01 to 0x03 are the red, green and blue gains. 0x04 holds the overlay gain in bits 3:0 and the range mode in bits 5:4. 0x05 to 0x07 are the red, green and blue black levels. 0x08 is the common trim and 0x09 to 0x0B are the red, green and blue trims. 0x0C holds the blank level in bits 5:0 and the variable-blank flag in bit 6. 0x0D holds these flags: bit 0 common brightness, bit 1 sync negative, bit 2 summed detect, bit 3 power save, bit 4 clamp negative, bit 5 test. 0x0E holds the detect level in bits 1:0 and the pin selector in bits 4:2.
- R9: brt_common_o is 1 when 0x0D bit 0 or 0x0E bit 2 is set. While it is 1, all three black outputs equal the green register (0x06); otherwise each channel shows its own register.
- R10: aux_a_sel_o is 2 (brightness DAC) when 0x0E bit 2 is set. Otherwise it is 1 (gain-control input) when 0x0E bit 4 is set, and 0 (composite sync) in all other cases. aux_b_sel_o equals 0x0E bit 3 (1 = video detect, 0 = trim DAC).
- R11: sda_pull_o is 0 outside the ninth clock of an acknowledged byte. It only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 MHz |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| gain_all_o | output | 8 | Overall gain |
| gain_r_o | output | 8 | Red gain |
| gain_g_o | output | 8 | Green gain |
| gain_b_o | output | 8 | Blue gain |
| osd_gain_o | output | 4 | Overlay gain |
| range_mode_o | output | 2 | Output-range mode |
| black_r_o | output | 8 | Effective red black level |
| black_g_o | output | 8 | Effective green black level |
| black_b_o | output | 8 | Effective blue black level |
| trim_all_o | output | 8 | Common trim DAC value |
| trim_r_o | output | 8 | Red trim DAC value |
| trim_g_o | output | 8 | Green trim DAC value |
| trim_b_o | output | 8 | Blue trim DAC value |
| blank_var_o | output | 1 | Blank level variable when 1 |
| blank_level_o | output | 6 | Blank level |
| brt_common_o | output | 1 | Effective common-brightness mode |
| sync_neg_o | output | 1 | Sync separator output negative |
| det_sum_o | output | 1 | Detector uses the summed channels |
| det_level_o | output | 2 | Detector threshold code |
| pwr_save_o | output | 1 | Power save |
| clamp_neg_o | output | 1 | Clamp pulse input is negative |
| test_mode_o | output | 1 | Test bit |
| aux_a_sel_o | output | 2 | Function of auxiliary output A |
| aux_b_sel_o | output | 1 | Function of auxiliary output B |

## Verification
The hardest states to reach from the ports are a byte cut off by a stop after only a few bits, followed by bus clocks with no start, and an index that runs past 0x0E towards 0xFF. The bench drives a full open-drain bus model that can stop after any number of bits and send bytes while the target is idle. It starts bursts at 0x0D and 0xFE, so bytes are discarded and the index saturates. A byte-level reference model predicts every acknowledge and every register value, and the outputs are compared against it on every clock outside the acknowledge windows.

// File: rtl/vfe_ctrl_pkg.sv
package vfe_ctrl_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 15;
  localparam int IDX_W    = BYTE_W;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] DEV_WRITE_ADDR = 8'h40;

  localparam int IDX_GAIN_ALL  = 0;
  localparam int IDX_GAIN_R    = 1;
  localparam int IDX_GAIN_G    = 2;
  localparam int IDX_GAIN_B    = 3;
  localparam int IDX_OSD_RANGE = 4;
  localparam int IDX_BLACK_R   = 5;
  localparam int IDX_BLACK_G   = 6;
  localparam int IDX_BLACK_B   = 7;
  localparam int IDX_TRIM_ALL  = 8;
  localparam int IDX_TRIM_R    = 9;
  localparam int IDX_TRIM_G    = 10;
  localparam int IDX_TRIM_B    = 11;
  localparam int IDX_BLANK     = 12;
  localparam int IDX_FLAGS     = 13;
  localparam int IDX_PINS      = 14;

  localparam logic [1:0] RANGE_MODE_RST = 2'd2;

  localparam logic [1:0] AUX_A_SYNC    = 2'd0;
  localparam logic [1:0] AUX_A_GAINCTL = 2'd1;
  localparam logic [1:0] AUX_A_BRIGHT  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INDEX, ST_DATA, ST_SKIP
  } rx_state_t;

  function automatic logic [BYTE_W-1:0] reg_reset_value(input int idx);
    return (idx == IDX_OSD_RANGE) ? BYTE_W'({RANGE_MODE_RST, 4'h0}) : '0;
  endfunction
endpackage

// File: rtl/vfe_i2c_sync.sv
module vfe_i2c_sync #(
  parameter int STAGES  = 2,
  parameter int SDA_LAG = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_now,
  output logic sda_now,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int SDA_LEN = STAGES + SDA_LAG;

  logic [STAGES:0]  scl_q;
  logic [SDA_LEN:0] sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_in};
      sda_q <= {sda_q[SDA_LEN-1:0], sda_in};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_now  = scl_q[STAGES-1];
  assign scl_prev = scl_q[STAGES];
  assign sda_now  = sda_q[SDA_LEN-1];
  assign sda_prev = sda_q[SDA_LEN];

  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/vfe_i2c_write_engine.sv
module vfe_i2c_write_engine
  import vfe_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_now,
  input  logic              sda_now,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  rx_state_t         state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ack_phase;
  logic [IDX_W-1:0]  ptr;

  logic receiving;
  assign receiving = (state == ST_ADDR) || (state == ST_INDEX) || (state == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      ack_phase <= 1'b0;
      sda_pull  <= 1'b0;
      ptr       <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det || stop_det) begin
        state     <= start_det ? ST_ADDR : ST_IDLE;
        bit_cnt   <= '0;
        ack_phase <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (receiving) begin
        if (scl_rise && !ack_phase && bit_cnt < CNT_W'(BYTE_W)) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_now};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall) begin
          if (ack_phase) begin
            ack_phase <= 1'b0;
            sda_pull  <= 1'b0;
            bit_cnt   <= '0;
          end else if (bit_cnt == CNT_W'(BYTE_W)) begin
            ack_phase <= 1'b1;
            case (state)
              ST_ADDR: begin
                if (shreg == DEV_WRITE_ADDR) begin
                  sda_pull <= 1'b1;
                  state    <= ST_INDEX;
                end else begin
                  state    <= ST_SKIP;
                end
              end
              ST_INDEX: begin
                ptr      <= shreg;
                sda_pull <= 1'b1;
                state    <= ST_DATA;
              end
              default: begin
                sda_pull <= 1'b1;
                wr_en    <= (ptr < IDX_W'(NUM_REGS));
                wr_idx   <= ptr;
                wr_data  <= shreg;
                if (ptr != IDX_MAX) ptr <= ptr + 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  assert_pull_rise_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_now);
  assert_write_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));
  assert_start_restarts_R6: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && bit_cnt == '0 && !sda_pull));
  assert_stop_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !wr_en && !sda_pull));
endmodule

// File: rtl/vfe_ctrl_reg_bank.sv
module vfe_ctrl_reg_bank
  import vfe_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [7:0]        gain_all_o,
  output logic [7:0]        gain_r_o,
  output logic [7:0]        gain_g_o,
  output logic [7:0]        gain_b_o,
  output logic [3:0]        osd_gain_o,
  output logic [1:0]        range_mode_o,
  output logic [7:0]        black_r_o,
  output logic [7:0]        black_g_o,
  output logic [7:0]        black_b_o,
  output logic [7:0]        trim_all_o,
  output logic [7:0]        trim_r_o,
  output logic [7:0]        trim_g_o,
  output logic [7:0]        trim_b_o,
  output logic              blank_var_o,
  output logic [5:0]        blank_level_o,
  output logic              brt_common_o,
  output logic              sync_neg_o,
  output logic              det_sum_o,
  output logic [1:0]        det_level_o,
  output logic              pwr_save_o,
  output logic              clamp_neg_o,
  output logic              test_mode_o,
  output logic [1:0]        aux_a_sel_o,
  output logic              aux_b_sel_o
);
  logic [BYTE_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst) regs[i] <= reg_reset_value(i);
      else if (wr_en && wr_idx == IDX_W'(i)) regs[i] <= wr_data;
    end
  end

  logic       brt_forced, brt_eff;
  logic [1:0] aux_a_next;
  always_comb begin
    brt_forced = regs[IDX_PINS][2];
    brt_eff    = regs[IDX_FLAGS][0] | brt_forced;
    if (brt_forced)             aux_a_next = AUX_A_BRIGHT;
    else if (regs[IDX_PINS][4]) aux_a_next = AUX_A_GAINCTL;
    else                        aux_a_next = AUX_A_SYNC;
  end

  logic unused_bits;
  assign unused_bits = ^{regs[IDX_OSD_RANGE][7:6], regs[IDX_BLANK][7],
                         regs[IDX_FLAGS][7:6], regs[IDX_PINS][7:5]};

  always_ff @(posedge clk) begin
    gain_all_o    <= regs[IDX_GAIN_ALL];
    gain_r_o      <= regs[IDX_GAIN_R];
    gain_g_o      <= regs[IDX_GAIN_G];
    gain_b_o      <= regs[IDX_GAIN_B];
    osd_gain_o    <= regs[IDX_OSD_RANGE][3:0];
    range_mode_o  <= regs[IDX_OSD_RANGE][5:4];
    black_r_o     <= brt_eff ? regs[IDX_BLACK_G] : regs[IDX_BLACK_R];
    black_g_o     <= regs[IDX_BLACK_G];
    black_b_o     <= brt_eff ? regs[IDX_BLACK_G] : regs[IDX_BLACK_B];
    trim_all_o    <= regs[IDX_TRIM_ALL];
    trim_r_o      <= regs[IDX_TRIM_R];
    trim_g_o      <= regs[IDX_TRIM_G];
    trim_b_o      <= regs[IDX_TRIM_B];
    blank_level_o <= regs[IDX_BLANK][5:0];
    blank_var_o   <= regs[IDX_BLANK][6];
    brt_common_o  <= brt_eff;
    sync_neg_o    <= regs[IDX_FLAGS][1];
    det_sum_o     <= regs[IDX_FLAGS][2];
    pwr_save_o    <= regs[IDX_FLAGS][3];
    clamp_neg_o   <= regs[IDX_FLAGS][4];
    test_mode_o   <= regs[IDX_FLAGS][5];
    det_level_o   <= regs[IDX_PINS][1:0];
    aux_a_sel_o   <= aux_a_next;
    aux_b_sel_o   <= regs[IDX_PINS][3];
  end

  assert_reset_range_mode_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(wr_en)) |=> (range_mode_o == RANGE_MODE_RST));
  assert_common_black_R9: assert property (@(posedge clk) disable iff (rst)
    brt_common_o |-> (black_r_o == black_g_o && black_b_o == black_g_o));
  assert_aux_bright_forces_common_R10: assert property (@(posedge clk) disable iff (rst)
    (aux_a_sel_o == AUX_A_BRIGHT) |-> brt_common_o);
endmodule

// File: rtl/vfe_ctrl_i2c_target.sv
module vfe_ctrl_i2c_target
  import vfe_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SDA_LAG     = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull_o,
  output logic [7:0] gain_all_o,
  output logic [7:0] gain_r_o,
  output logic [7:0] gain_g_o,
  output logic [7:0] gain_b_o,
  output logic [3:0] osd_gain_o,
  output logic [1:0] range_mode_o,
  output logic [7:0] black_r_o,
  output logic [7:0] black_g_o,
  output logic [7:0] black_b_o,
  output logic [7:0] trim_all_o,
  output logic [7:0] trim_r_o,
  output logic [7:0] trim_g_o,
  output logic [7:0] trim_b_o,
  output logic       blank_var_o,
  output logic [5:0] blank_level_o,
  output logic       brt_common_o,
  output logic       sync_neg_o,
  output logic       det_sum_o,
  output logic [1:0] det_level_o,
  output logic       pwr_save_o,
  output logic       clamp_neg_o,
  output logic       test_mode_o,
  output logic [1:0] aux_a_sel_o,
  output logic       aux_b_sel_o
);
  logic scl_now, sda_now, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  vfe_i2c_sync #(.STAGES(SYNC_STAGES), .SDA_LAG(SDA_LAG)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_now(scl_now), .sda_now(sda_now), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  vfe_i2c_write_engine u_engine (
    .clk(clk), .rst(rst), .scl_now(scl_now), .sda_now(sda_now),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull_o), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  vfe_ctrl_reg_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .gain_all_o(gain_all_o), .gain_r_o(gain_r_o), .gain_g_o(gain_g_o),
    .gain_b_o(gain_b_o), .osd_gain_o(osd_gain_o), .range_mode_o(range_mode_o),
    .black_r_o(black_r_o), .black_g_o(black_g_o), .black_b_o(black_b_o),
    .trim_all_o(trim_all_o), .trim_r_o(trim_r_o), .trim_g_o(trim_g_o),
    .trim_b_o(trim_b_o), .blank_var_o(blank_var_o), .blank_level_o(blank_level_o),
    .brt_common_o(brt_common_o), .sync_neg_o(sync_neg_o), .det_sum_o(det_sum_o),
    .det_level_o(det_level_o), .pwr_save_o(pwr_save_o), .clamp_neg_o(clamp_neg_o),
    .test_mode_o(test_mode_o), .aux_a_sel_o(aux_a_sel_o), .aux_b_sel_o(aux_b_sel_o)
  );
endmodule

// File: tb/tb_vfe_ctrl_i2c_target.sv
`timescale 1ns/1ps
module tb_vfe_ctrl_i2c_target;
  localparam int Q = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, win = 1'b0, done = 1'b0;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  logic [7:0] gain_all, gain_r, gain_g, gain_b, black_r, black_g, black_b;
  logic [7:0] trim_all, trim_r, trim_g, trim_b;
  logic [3:0] osd_gain;
  logic [1:0] range_mode, det_level, aux_a;
  logic [5:0] blank_level;
  logic blank_var, brt_common, sync_neg, det_sum, pwr_save, clamp_neg, test_mode, aux_b;

  vfe_ctrl_i2c_target dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_pull_o(sda_pull),
    .gain_all_o(gain_all), .gain_r_o(gain_r), .gain_g_o(gain_g), .gain_b_o(gain_b),
    .osd_gain_o(osd_gain), .range_mode_o(range_mode), .black_r_o(black_r),
    .black_g_o(black_g), .black_b_o(black_b), .trim_all_o(trim_all),
    .trim_r_o(trim_r), .trim_g_o(trim_g), .trim_b_o(trim_b),
    .blank_var_o(blank_var), .blank_level_o(blank_level), .brt_common_o(brt_common),
    .sync_neg_o(sync_neg), .det_sum_o(det_sum), .det_level_o(det_level),
    .pwr_save_o(pwr_save), .clamp_neg_o(clamp_neg), .test_mode_o(test_mode),
    .aux_a_sel_o(aux_a), .aux_b_sel_o(aux_b)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_r [15];
  int mst = 0;   // 0 idle, 1 address, 2 index, 3 data, 4 ignore
  int ptr = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [127:0] act_raw();
    return 128'({gain_all, gain_r, gain_g, gain_b, osd_gain, range_mode,
                 trim_all, trim_r, trim_g, trim_b, blank_var, blank_level,
                 sync_neg, det_sum, pwr_save, clamp_neg, test_mode, det_level});
  endfunction
  function automatic logic [127:0] exp_raw();
    return 128'({exp_r[0], exp_r[1], exp_r[2], exp_r[3], exp_r[4][3:0], exp_r[4][5:4],
                 exp_r[8], exp_r[9], exp_r[10], exp_r[11], exp_r[12][6], exp_r[12][5:0],
                 exp_r[13][1], exp_r[13][2], exp_r[13][3], exp_r[13][4], exp_r[13][5],
                 exp_r[14][1:0]});
  endfunction
  function automatic logic [127:0] exp_black();
    logic c;
    c = exp_r[13][0] | exp_r[14][2];
    return 128'({c, c ? exp_r[6] : exp_r[5], exp_r[6], c ? exp_r[6] : exp_r[7]});
  endfunction
  function automatic logic [127:0] exp_aux();
    logic [1:0] a;
    a = exp_r[14][2] ? 2'd2 : (exp_r[14][4] ? 2'd1 : 2'd0);
    return 128'({a, exp_r[14][3]});
  endfunction

  always @(negedge clk) begin
    if (!rst && !win && !done) begin
      chk("R8 field map", act_raw(), exp_raw());
      chk("R9 effective black", 128'({brt_common, black_r, black_g, black_b}), exp_black());
      chk("R10 aux select", 128'({aux_a, aux_b}), exp_aux());
      chk("R11 pull released", 128'(sda_pull), 128'(0));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
    mst = 1;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
    mst = 0;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    logic got, want;
    for (int i = 7; i >= 1; i--) send_bit(b[i]);
    sda_m = b[0]; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    win = 1'b1;
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    got = (sda_line == 1'b0);
    want = 1'b0;
    case (mst)
      1: begin want = (b == 8'h40); mst = want ? 2 : 4; end
      2: begin want = 1'b1; ptr = b; mst = 3; end
      3: begin
        want = 1'b1;
        if (ptr <= 14) exp_r[ptr] = b;
        if (ptr != 255) ptr++;
      end
      default: want = 1'b0;
    endcase
    chk(tag, 128'(got), 128'(want));
    tick(Q);
    scl_m = 1'b0; tick(Q);
    win = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 15; i++) exp_r[i] = 8'h00;
    exp_r[4] = 8'h20;
    tick(10);
    rst = 1'b0;
    tick(3);
    // R1: reset values at the ports
    chk("R1 reset range mode", 128'(range_mode), 128'(2));
    chk("R1 reset others", 128'({gain_all, black_r, trim_all, brt_common, aux_a, sda_pull}), 128'(0));

    // R2 R4 R8: full burst from index 0
    bus_start();
    send_byte(8'h40, "R2 address ack");
    send_byte(8'h00, "R4 index ack");
    for (int i = 0; i < 15; i++) send_byte(8'(i * 37 + 11), "R4 burst data ack");
    bus_stop();
    tick(Q);
    chk("R4 burst first and last", 128'({gain_all, det_level}), 128'({8'd11, exp_r[14][1:0]}));
    chk("R8 range from 0x04", 128'(range_mode), 128'(exp_r[4][5:4]));

    // R9: common mode by flag, then forced by pin selector
    bus_start();
    send_byte(8'h40, "R2 address ack");
    send_byte(8'h0D, "R4 index ack");
    send_byte(8'h01, "R9 flag write ack");
    send_byte(8'h00, "R9 pins write ack");
    bus_stop();
    tick(Q);
    chk("R9 common by flag", 128'({brt_common, black_r, black_b}), 128'({1'b1, exp_r[6], exp_r[6]}));
    bus_start();
    send_byte(8'h40, "R2 address ack");
    send_byte(8'h0D, "R4 index ack");
    send_byte(8'h00, "R9 flag clear ack");
    send_byte(8'h04, "R10 pins forced ack");
    bus_stop();
    tick(Q);
    chk("R9 common forced by pins", 128'({brt_common, black_r}), 128'({1'b1, exp_r[6]}));
    chk("R10 aux A brightness", 128'({aux_a, aux_b}), 128'({2'd2, 1'b0}));
    bus_start();
    send_byte(8'h40, "R2 address ack");
    send_byte(8'h0E, "R4 index ack");
    send_byte(8'h08, "R10 pins detect ack");
    bus_stop();
    tick(Q);
    chk("R9 independent black", 128'({brt_common, black_r, black_b}), 128'({1'b0, exp_r[5], exp_r[7]}));
    chk("R10 aux B detect", 128'({aux_a, aux_b}), 128'({2'd0, 1'b1}));

    // R5: run past the last index, then saturate near 0xFF
    bus_start();
    send_byte(8'h40, "R2 address ack");
    send_byte(8'h0D, "R4 index ack");
    for (int i = 0; i < 4; i++) send_byte(8'(8'h50 + i), "R5 ack past end");
    bus_stop();
    bus_start();
    send_byte(8'h40, "R2 address ack");
    send_byte(8'hFE, "R5 high index ack");
    for (int i = 0; i < 3; i++) send_byte(8'hC3, "R5 discarded ack");
    bus_stop();
    tick(Q);
    chk("R5 no wrap to index 0", 128'({gain_all, gain_r}), 128'({exp_r[0], exp_r[1]}));

    // R3: wrong address and read request
    bus_start();
    send_byte(8'h42, "R3 wrong address nack");
    send_byte(8'h00, "R3 ignored byte nack");
    send_byte(8'hAA, "R3 ignored byte nack");
    bus_stop();
    bus_start();
    send_byte(8'h41, "R3 read request nack");
    send_byte(8'h01, "R3 ignored byte nack");
    bus_stop();
    tick(Q);
    chk("R3 registers untouched", 128'({gain_all, gain_r}), 128'({exp_r[0], exp_r[1]}));

    // R6: repeated start changes the index
    bus_start();
    send_byte(8'h40, "R2 address ack");
    send_byte(8'h01, "R6 first index ack");
    send_byte(8'hA5, "R6 first data ack");
    bus_start();
    send_byte(8'h40, "R6 readdress ack");
    send_byte(8'h03, "R6 new index ack");
    send_byte(8'h5A, "R6 new data ack");
    bus_stop();
    tick(Q);
    chk("R6 both writes", 128'({gain_r, gain_g, gain_b}), 128'({8'hA5, exp_r[2], 8'h5A}));

    // R7: stop inside a byte, then clocks without a start
    bus_start();
    send_byte(8'h40, "R2 address ack");
    send_byte(8'h02, "R7 index ack");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    send_byte(8'h77, "R7 byte after stop nack");
    tick(Q);
    chk("R7 partial not committed", 128'(gain_g), 128'(exp_r[2]));
    bus_start();
    send_byte(8'h40, "R7 resume address ack");
    send_byte(8'h02, "R7 resume index ack");
    send_byte(8'h3C, "R7 resume data ack");
    bus_stop();
    tick(Q);
    chk("R7 resumed write", 128'(gain_g), 128'(8'h3C));

    finish_run();
  end
endmodule